// File: doc/BRIEF.md
# Dual-Window Peripheral Access Control Register Bank

This block holds the security and privilege settings for ten peripheral protection controllers and turns them into per-port control wires. Every controller has three masks: a non-secure mask, a privilege mask used while a port is secure, and a privilege mask used while a port is non-secure. The non-secure and secure-privilege masks can only be reached through the secure register window. The non-secure-privilege mask can only be reached through the non-secure window. Each window has its own request port, so both can act in the same cycle.

For every port, the block drives a non-secure wire that copies the port's non-secure bit. It also drives a privilege wire. The port's own non-secure bit selects which of the two privilege masks feeds that wire. The secure window also holds a 1-bit security-response setting and a 2-bit non-secure-callable setting, and each of these drives its own output. Some offsets are reserved: they read as zero and ignore writes. Writes narrower than a word are dropped. Byte and halfword reads return the addressed lane.

Top module: `pac_regbank`

## Requirements
- R1: A secure-window word write to 0x60+4k (AHB expansion controllers, k=0..3), 0x70+4k (internal controllers, k=0..1) or 0x80+4k (APB expansion controllers, k=0..3) loads that controller's non-secure mask. Address bits [3:2] select the controller within the group. Controllers are numbered 0-3, 4-5 and 6-9 in that group order. Controller c occupies bits [16c+15:16c] of `nonsec_o` and `priv_o`, and `nonsec_o` there equals the mask.
- R2: Secure-window word writes to 0xa0, 0xb0 and 0xc0 (same grouping and indexing) load the secure-privilege masks. These offsets read back the same masks.
- R3: Non-secure-window word writes to 0xa0, 0xb0 and 0xc0 (same grouping) load the non-secure-privilege masks. The non-secure window reads them back at those offsets.
- R4: For each port i, `priv_o` bit i takes the non-secure-privilege mask bit when the non-secure mask bit i is 1, and the secure-privilege mask bit otherwise.
- R5: Every mask write keeps only the controller's port count of low bits. The defaults are 16, 14, 2 and 16 ports for the AHB expansion, internal 0, internal 1 and APB expansion controllers. All higher bits read back and drive as 0.
- R6: Secure offsets 0x50 and 0x90, non-secure offset 0x90, and all other unmapped offsets (including internal controller slot 0x78) read as zero and ignore writes.
- R7: A secure word write to 0x10 sets `resp_cfg_o` to data bit 0. A secure word write to 0x14 sets `nsc_cfg_o` to data bits [1:0]. Both read back.
- R8: Writes with size 0 (byte) or 1 (halfword) change no register and no output. Only size 2 (word) writes take effect.
- R9: Reads return data one cycle after the request. Size 0 returns the byte at address bits [1:0]. Size 1 returns the halfword at address bit 1. Size 2 returns the whole word.
- R10: Reset clears every mask and both configuration registers, so all outputs read 0.
- R11: Outputs change in the cycle after the write. A secure write and a non-secure write in the same cycle both take effect.
- R12: The non-secure window cannot reach the non-secure masks, the secure-privilege masks or the configuration registers. The secure window reads offset 0xc0+4k as the secure-privilege mask, never the non-secure-privilege one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_en | input | 1 | Secure window request |
| s_we | input | 1 | Secure window write (1) or read (0) |
| s_size | input | 2 | Secure access size: 0 byte, 1 half, 2 word |
| s_addr | input | 12 | Secure window byte offset |
| s_wdata | input | 32 | Secure write data |
| s_rdata | output | 32 | Secure read data, one cycle after request |
| n_en | input | 1 | Non-secure window request |
| n_we | input | 1 | Non-secure window write (1) or read (0) |
| n_size | input | 2 | Non-secure access size |
| n_addr | input | 12 | Non-secure window byte offset |
| n_wdata | input | 32 | Non-secure write data |
| n_rdata | output | 32 | Non-secure read data, one cycle after request |
| nonsec_o | output | 160 | Per-port non-secure wires, 16 per controller |
| priv_o | output | 160 | Per-port privilege wires, 16 per controller |
| resp_cfg_o | output | 1 | Security response setting |
| nsc_cfg_o | output | 2 | Non-secure-callable setting |

## Verification
The secure window and the non-secure window can write the same controller in one cycle: one sets the non-secure mask and the other sets the non-secure-privilege mask, and together they decide that controller's privilege wires. The bench drives both request ports in a single cycle for controller 9, after it has loaded a distinct secure-privilege mask. It then checks two things. Just before the capturing edge, every output must still show the old values. After that edge, the privilege wires must take, bit by bit, the new non-secure-privilege bits where the new non-secure bits are set and the older secure-privilege bits elsewhere.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int NUM_CTRL = 10;
  localparam int SLOT_W   = 16;
  localparam int IDX_W    = 4;

  typedef enum logic [2:0] {K_NONE, K_NS, K_SP, K_NSP, K_RESP, K_NSC} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [IDX_W-1:0]  idx;
  } dec_t;

  // Map a window offset to the register it names.
  function automatic dec_t decode(input logic secure, input logic [11:0] a);
    dec_t d;
    logic [IDX_W-1:0] base;
    logic ok;
    logic upper;
    d.kind = K_NONE;
    d.idx  = '0;
    base   = '0;
    ok     = 1'b0;
    upper  = (a[7:4] == 4'ha) || (a[7:4] == 4'hb) || (a[7:4] == 4'hc);
    if (a[11:8] == 4'h0) begin
      case (a[7:4])
        4'h6, 4'ha: begin base = 4'd0; ok = 1'b1; end
        4'h7, 4'hb: begin base = 4'd4; ok = (a[3:2] < 2'd2); end
        4'h8, 4'hc: begin base = 4'd6; ok = 1'b1; end
        default:    ok = 1'b0;
      endcase
    end
    if (ok) begin
      d.idx = base + {2'b00, a[3:2]};
      if (secure)     d.kind = upper ? K_SP : K_NS;
      else if (upper) d.kind = K_NSP;
    end
    if (secure && a[11:2] == 10'h004) d.kind = K_RESP;
    if (secure && a[11:2] == 10'h005) d.kind = K_NSC;
    return d;
  endfunction

  // Extract the addressed lane for a narrow read.
  function automatic logic [31:0] pick_lane(input logic [31:0] w, input logic [1:0] off,
                                            input logic [1:0] sz);
    logic [31:0] r;
    case (sz)
      2'd0:    r = (w >> {off, 3'b000}) & 32'h0000_00ff;
      2'd1:    r = (w >> {off[1], 4'h0}) & 32'h0000_ffff;
      default: r = w;
    endcase
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] port_mask(input int ports);
    logic [SLOT_W:0] one;
    one = 1;
    return SLOT_W'((one << ports) - 1'b1);
  endfunction
endpackage

// File: rtl/pac_win_dec.sv
module pac_win_dec
  import pac_pkg::*;
#(
  parameter bit SECURE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                we,
  input  logic [1:0]          size,
  input  logic [11:0]         addr,
  output dec_t                rd_dec,
  output logic [NUM_CTRL-1:0] ns_wr,
  output logic [NUM_CTRL-1:0] sp_wr,
  output logic [NUM_CTRL-1:0] nsp_wr,
  output logic                resp_wr,
  output logic                nsc_wr
);
  logic word_wr;
  dec_t d;

  assign d       = decode(SECURE, addr);
  assign rd_dec  = d;
  assign word_wr = en && we && (size == 2'd2);

  always_comb begin
    ns_wr   = '0;
    sp_wr   = '0;
    nsp_wr  = '0;
    resp_wr = 1'b0;
    nsc_wr  = 1'b0;
    if (word_wr) begin
      case (d.kind)
        K_NS:    ns_wr[d.idx]  = 1'b1;
        K_SP:    sp_wr[d.idx]  = 1'b1;
        K_NSP:   nsp_wr[d.idx] = 1'b1;
        K_RESP:  resp_wr = 1'b1;
        K_NSC:   nsc_wr  = 1'b1;
        default: ;
      endcase
    end
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ns_wr, sp_wr, nsp_wr, resp_wr, nsc_wr}));

  // R8
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && size != 2'd2) |-> ({ns_wr, sp_wr, nsp_wr, resp_wr, nsc_wr} == '0));
endmodule

// File: rtl/pac_slot.sv
module pac_slot
  import pac_pkg::*;
#(
  parameter int PORTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ns,
  input  logic              wr_sp,
  input  logic              wr_nsp,
  input  logic [SLOT_W-1:0] sec_wdata,
  input  logic [SLOT_W-1:0] nsec_wdata,
  output logic [SLOT_W-1:0] ns_q,
  output logic [SLOT_W-1:0] sp_q,
  output logic [SLOT_W-1:0] nsp_q,
  output logic [SLOT_W-1:0] nonsec_o,
  output logic [SLOT_W-1:0] priv_o
);
  localparam logic [SLOT_W-1:0] MASK = port_mask(PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      if (wr_ns)  ns_q  <= sec_wdata & MASK;
      if (wr_sp)  sp_q  <= sec_wdata & MASK;
      if (wr_nsp) nsp_q <= nsec_wdata & MASK;
    end
  end

  assign nonsec_o = ns_q;

  for (genvar i = 0; i < SLOT_W; i++) begin : g_port
    assign priv_o[i] = ns_q[i] ? nsp_q[i] : sp_q[i];
  end

  // R1
  ns_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ns |=> nonsec_o == ($past(sec_wdata) & MASK));

  // R11
  priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ns || wr_sp || wr_nsp) |=> $stable(priv_o));

  // R4
  priv_nsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nsp && !wr_ns) |=> ((priv_o ^ ($past(nsec_wdata) & MASK)) & nonsec_o) == '0);
endmodule

// File: rtl/pac_regbank.sv
module pac_regbank
  import pac_pkg::*;
#(
  parameter int AHBX_PORTS  = 16,
  parameter int APBI0_PORTS = 14,
  parameter int APBI1_PORTS = 2,
  parameter int APBX_PORTS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_en,
  input  logic                         s_we,
  input  logic [1:0]                   s_size,
  input  logic [11:0]                  s_addr,
  input  logic [31:0]                  s_wdata,
  output logic [31:0]                  s_rdata,
  input  logic                         n_en,
  input  logic                         n_we,
  input  logic [1:0]                   n_size,
  input  logic [11:0]                  n_addr,
  input  logic [31:0]                  n_wdata,
  output logic [31:0]                  n_rdata,
  output logic [NUM_CTRL*SLOT_W-1:0]   nonsec_o,
  output logic [NUM_CTRL*SLOT_W-1:0]   priv_o,
  output logic                         resp_cfg_o,
  output logic [1:0]                   nsc_cfg_o
);
  dec_t s_dec, n_dec;
  logic [NUM_CTRL-1:0] s_ns_wr, s_sp_wr, s_nsp_wr_unused;
  logic [NUM_CTRL-1:0] n_ns_wr_unused, n_sp_wr_unused, n_nsp_wr;
  logic s_resp_wr, s_nsc_wr, n_resp_wr_unused, n_nsc_wr_unused;
  logic [SLOT_W-1:0] ns_all [NUM_CTRL];
  logic [SLOT_W-1:0] sp_all [NUM_CTRL];
  logic [SLOT_W-1:0] nsp_all [NUM_CTRL];
  logic [31:0] s_word, n_word;

  pac_win_dec #(.SECURE(1'b1)) u_sdec (
    .clk, .rst_n, .en(s_en), .we(s_we), .size(s_size), .addr(s_addr),
    .rd_dec(s_dec), .ns_wr(s_ns_wr), .sp_wr(s_sp_wr), .nsp_wr(s_nsp_wr_unused),
    .resp_wr(s_resp_wr), .nsc_wr(s_nsc_wr));

  pac_win_dec #(.SECURE(1'b0)) u_ndec (
    .clk, .rst_n, .en(n_en), .we(n_we), .size(n_size), .addr(n_addr),
    .rd_dec(n_dec), .ns_wr(n_ns_wr_unused), .sp_wr(n_sp_wr_unused), .nsp_wr(n_nsp_wr),
    .resp_wr(n_resp_wr_unused), .nsc_wr(n_nsc_wr_unused));

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    localparam int P = (c < 4) ? AHBX_PORTS : (c == 4) ? APBI0_PORTS :
                       (c == 5) ? APBI1_PORTS : APBX_PORTS;
    pac_slot #(.PORTS(P)) u_slot (
      .clk, .rst_n,
      .wr_ns(s_ns_wr[c]), .wr_sp(s_sp_wr[c]), .wr_nsp(n_nsp_wr[c]),
      .sec_wdata(s_wdata[SLOT_W-1:0]), .nsec_wdata(n_wdata[SLOT_W-1:0]),
      .ns_q(ns_all[c]), .sp_q(sp_all[c]), .nsp_q(nsp_all[c]),
      .nonsec_o(nonsec_o[c*SLOT_W +: SLOT_W]), .priv_o(priv_o[c*SLOT_W +: SLOT_W]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_cfg_o <= 1'b0;
      nsc_cfg_o  <= 2'b00;
    end else begin
      if (s_resp_wr) resp_cfg_o <= s_wdata[0];
      if (s_nsc_wr)  nsc_cfg_o  <= s_wdata[1:0];
    end
  end

  always_comb begin
    s_word = '0;
    case (s_dec.kind)
      K_NS:    s_word = {16'h0, ns_all[s_dec.idx]};
      K_SP:    s_word = {16'h0, sp_all[s_dec.idx]};
      K_RESP:  s_word = {31'h0, resp_cfg_o};
      K_NSC:   s_word = {30'h0, nsc_cfg_o};
      default: s_word = '0;
    endcase
    n_word = (n_dec.kind == K_NSP) ? {16'h0, nsp_all[n_dec.idx]} : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_rdata <= '0;
      n_rdata <= '0;
    end else begin
      if (s_en && !s_we) s_rdata <= pick_lane(s_word, s_addr[1:0], s_size);
      if (n_en && !n_we) n_rdata <= pick_lane(n_word, n_addr[1:0], n_size);
    end
  end

  // R6
  ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && !s_we && (s_addr[11:2] == 10'h014 || s_addr[11:2] == 10'h024)) |=> s_rdata == '0);

  // R6
  ns_ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_en && !n_we && n_addr[11:2] == 10'h024) |=> n_rdata == '0);

  // R7
  nsc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && s_we && s_size == 2'd2 && s_addr[11:2] == 10'h005) |=> nsc_cfg_o == $past(s_wdata[1:0]));

  // R8
  narrow_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && s_we && s_size != 2'd2 && !(n_en && n_we)) |=>
      $stable(nonsec_o) && $stable(priv_o) && $stable(resp_cfg_o) && $stable(nsc_cfg_o));

  // R12
  ns_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_en && n_we && !(s_en && s_we)) |=>
      $stable(nonsec_o) && $stable(resp_cfg_o) && $stable(nsc_cfg_o));
endmodule

// File: tb/sim_pac_regbank.sv
`timescale 1ns/1ps
module sim_pac_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_en = 0, s_we = 0, n_en = 0, n_we = 0;
  logic [1:0] s_size = 0, n_size = 0;
  logic [11:0] s_addr = 0, n_addr = 0;
  logic [31:0] s_wdata = 0, n_wdata = 0;
  logic [31:0] s_rdata, n_rdata;
  logic [159:0] nonsec_o, priv_o;
  logic resp_cfg_o;
  logic [1:0] nsc_cfg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_ns [10];
  logic [15:0] m_sp [10];
  logic [15:0] m_nsp [10];
  logic m_resp;
  logic [1:0] m_nsc;

  always #4 clk = ~clk;

  pac_regbank u0 (.*);

  task automatic chk(input string req, input logic [159:0] got, input logic [159:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req);
    logic [159:0] en, ep;
    for (int c = 0; c < 10; c++) begin
      en[c*16 +: 16] = m_ns[c];
      for (int i = 0; i < 16; i++)
        ep[c*16+i] = m_ns[c][i] ? m_nsp[c][i] : m_sp[c][i];
    end
    chk({req, " nonsec"}, nonsec_o, en);
    chk({req, " priv"}, priv_o, ep);
    chk({req, " cfg"}, {157'h0, resp_cfg_o, nsc_cfg_o}, {157'h0, m_resp, m_nsc});
  endtask

  task automatic bus(input bit sec, input bit we, input logic [1:0] sz, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    if (sec) begin s_en = 1; s_we = we; s_size = sz; s_addr = a; s_wdata = d; end
    else     begin n_en = 1; n_we = we; n_size = sz; n_addr = a; n_wdata = d; end
    @(negedge clk);
    rd = sec ? s_rdata : n_rdata;
    s_en = 0; n_en = 0; s_we = 0; n_we = 0;
  endtask

  task automatic sw(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] x;
    bus(1, 1, 2'd2, a, d, x);
  endtask

  task automatic nw(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] x;
    bus(0, 1, 2'd2, a, d, x);
  endtask

  task automatic rdchk(input string req, input bit sec, input logic [1:0] sz,
                       input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] r;
    bus(sec, 0, sz, a, 32'h0, r);
    chk(req, {128'h0, r}, {128'h0, exp});
  endtask

  task automatic t_reset;
    chk_out("R10");
    rdchk("R10 secure read", 1, 2'd2, 12'h060, 32'h0);
    rdchk("R10 nonsecure read", 0, 2'd2, 12'h0a0, 32'h0);
  endtask

  task automatic t_ns;
    sw(12'h064, 32'hFFFF_A5A5); m_ns[1] = 16'hA5A5;
    sw(12'h088, 32'h0000_1234); m_ns[8] = 16'h1234;
    chk_out("R1");
    rdchk("R1 readback", 1, 2'd2, 12'h064, 32'h0000_A5A5);
  endtask

  task automatic t_sp;
    sw(12'h0a4, 32'h0000_0F0F); m_sp[1] = 16'h0F0F;
    chk_out("R2");
    rdchk("R2 readback", 1, 2'd2, 12'h0a4, 32'h0000_0F0F);
  endtask

  task automatic t_nsp;
    nw(12'h0a4, 32'h0000_FFFF); m_nsp[1] = 16'hFFFF;
    chk_out("R4 nsp selected");
    rdchk("R3 readback", 0, 2'd2, 12'h0a4, 32'h0000_FFFF);
    sw(12'h064, 32'h0); m_ns[1] = 16'h0;
    chk_out("R4 sp selected");
  endtask

  task automatic t_mask;
    sw(12'h070, 32'hFFFF_FFFF); m_ns[4] = 16'h3FFF;
    sw(12'h074, 32'hFFFF_FFFF); m_ns[5] = 16'h0003;
    chk_out("R5");
    rdchk("R5 readback", 1, 2'd2, 12'h074, 32'h3);
    nw(12'h0b4, 32'hFFFF_FFFF); m_nsp[5] = 16'h0003;
    rdchk("R5 nsp readback", 0, 2'd2, 12'h0b4, 32'h3);
  endtask

  task automatic t_ro;
    sw(12'h050, 32'hFFFF_FFFF);
    sw(12'h090, 32'hFFFF_FFFF);
    sw(12'h078, 32'hFFFF_FFFF);
    sw(12'h200, 32'hFFFF_FFFF);
    nw(12'h090, 32'hFFFF_FFFF);
    chk_out("R6");
    rdchk("R6 s 0x50", 1, 2'd2, 12'h050, 32'h0);
    rdchk("R6 s 0x90", 1, 2'd2, 12'h090, 32'h0);
    rdchk("R6 s 0x78", 1, 2'd2, 12'h078, 32'h0);
    rdchk("R6 n 0x90", 0, 2'd2, 12'h090, 32'h0);
  endtask

  task automatic t_cfg;
    sw(12'h010, 32'hFFFF_FFFF); m_resp = 1'b1;
    sw(12'h014, 32'hFFFF_FFFF); m_nsc = 2'd3;
    chk_out("R7");
    rdchk("R7 resp readback", 1, 2'd2, 12'h010, 32'h1);
    rdchk("R7 nsc readback", 1, 2'd2, 12'h014, 32'h3);
    sw(12'h014, 32'h2); m_nsc = 2'd2;
    chk_out("R7 nsc=2");
  endtask

  task automatic t_narrow;
    logic [31:0] x;
    bus(1, 1, 2'd0, 12'h064, 32'hFFFF_FFFF, x);
    bus(1, 1, 2'd1, 12'h064, 32'hFFFF_FFFF, x);
    bus(1, 1, 2'd0, 12'h010, 32'h0, x);
    bus(0, 1, 2'd1, 12'h0a8, 32'hFFFF_FFFF, x);
    chk_out("R8");
    rdchk("R8 readback", 1, 2'd2, 12'h064, 32'h0);
    rdchk("R8 nsp readback", 0, 2'd2, 12'h0a8, 32'h0);
  endtask

  task automatic t_lane;
    sw(12'h084, 32'h0000_BEEF); m_ns[7] = 16'hBEEF;
    nw(12'h0c4, 32'h0000_1357); m_nsp[7] = 16'h1357;
    chk_out("R9 setup");
    rdchk("R9 byte0", 1, 2'd0, 12'h084, 32'hEF);
    rdchk("R9 byte1", 1, 2'd0, 12'h085, 32'hBE);
    rdchk("R9 byte3", 1, 2'd0, 12'h087, 32'h0);
    rdchk("R9 half0", 1, 2'd1, 12'h084, 32'hBEEF);
    rdchk("R9 half1", 1, 2'd1, 12'h086, 32'h0);
    rdchk("R9 n byte1", 0, 2'd0, 12'h0c5, 32'h13);
    rdchk("R9 n half1", 0, 2'd1, 12'h0c6, 32'h0);
  endtask

  task automatic t_dual;
    sw(12'h0cc, 32'h0000_F000); m_sp[9] = 16'hF000;
    @(negedge clk);
    s_en = 1; s_we = 1; s_size = 2'd2; s_addr = 12'h08c; s_wdata = 32'h0000_00FF;
    n_en = 1; n_we = 1; n_size = 2'd2; n_addr = 12'h0cc; n_wdata = 32'h0000_0F0F;
    #3;
    chk_out("R11 before edge");
    @(negedge clk);
    s_en = 0; n_en = 0; s_we = 0; n_we = 0;
    m_ns[9] = 16'h00FF; m_nsp[9] = 16'h0F0F;
    chk_out("R11 after edge");
    chk("R11 priv ctrl9", {144'h0, priv_o[159:144]}, {144'h0, 16'hF00F});
  endtask

  task automatic t_iso;
    nw(12'h064, 32'hFFFF_FFFF);
    nw(12'h0cc + 12'h0, 32'h0000_0F0F);
    nw(12'h010, 32'h0);
    nw(12'h014, 32'h0);
    chk_out("R12");
    rdchk("R12 secure sees sp", 1, 2'd2, 12'h0cc, 32'h0000_F000);
    rdchk("R12 ns window no ns mask", 0, 2'd2, 12'h08c, 32'h0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 10; c++) begin
      m_ns[c] = '0; m_sp[c] = '0; m_nsp[c] = '0;
    end
    m_resp = 0; m_nsc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ns;
    t_sp;
    t_nsp;
    t_mask;
    t_ro;
    t_cfg;
    t_narrow;
    t_lane;
    t_dual;
    t_iso;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run;
    end
  end
endmodule